// File: doc/BRIEF.md
# Guarded Handshake Clock-Domain Crossing

This block carries one multi-bit word at a time from a sender clock domain into an unrelated receiver clock domain. The word travels on its own set of wires and is held steady by the sender while it is in flight. A pair of single-bit guards travels alongside it. A request guard says a word is waiting, and an acknowledge guard says the receiver has taken it. The two guards follow a four-phase return-to-zero exchange.

Each guard enters the opposite domain through one synchronizer flop. This flop is a separate module with a fixed, easily found instance name; it is never an inferred register. The receive-side synchronizer runs on its own receive sync clock port, which is routed in parallel with the receive clock. Only the synchronized copies of the guards reach the state machines on either side.

The sender offers words through a ready/valid pair and shows a busy flag while a transfer is open. The receiver takes a word only when its consumer signals ready. It presents each word with a valid pulse one receive-clock cycle wide.

Top module: `ghs_cdc`

## Requirements
- R1: While the resets are high, s_ready is 1, s_busy is 0 and r_valid is 0.
- R2: A word is taken at a rising s_clk edge where s_valid and s_ready are both 1. From the next cycle on, s_busy is 1 and s_ready is 0.
- R3: While s_busy stays high, the word the sender drives across the domain boundary does not change.
- R4: s_busy stays high until the synchronized acknowledge has returned low. By the time s_busy falls, the receiver has already presented the word. No new word is taken while s_busy is high.
- R5: Each received word appears on r_data together with an r_valid pulse exactly one r_clk cycle wide. r_valid is only ever high in a cycle whose starting edge saw r_ready high.
- R6: While r_ready is held low, a pending transfer waits. r_valid stays low, s_busy stays high, and no word is lost.
- R7: Every word the sender takes arrives at the receiver exactly once, in order, and with the same value.
- R8: The receiver raises its acknowledge only after its synchronizer has shown the request high. The receive-side synchronizer is clocked by r_sync_clk and reset asynchronously.
- R9: The sender lowers its request only after its synchronized acknowledge has been seen high. It raises a new request only while the synchronized acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Sender clock |
| s_rst | input | 1 | Sender reset, active high |
| s_valid | input | 1 | Sender offers a word |
| s_data | input | DATA_W | Word offered by the sender |
| s_ready | output | 1 | Sender side can take a word |
| s_busy | output | 1 | A transfer is open on the sender side |
| r_clk | input | 1 | Receive clock for the receiver logic |
| r_sync_clk | input | 1 | Receive sync clock for the request synchronizer |
| r_rst | input | 1 | Receiver reset, active high |
| r_ready | input | 1 | Consumer can take a word |
| r_valid | output | 1 | One-cycle pulse marking a delivered word |
| r_data | output | DATA_W | Delivered word |

## Verification
The bench uses two unrelated clock periods and compares every delivered word against a queue of accepted words. The word patterns are back-to-back incrementing words, all-zero and all-one words, and alternating-bit words. Back-to-back offers show whether a second word slips in while a transfer is still open. The bit patterns expose stuck or swapped data lines. Sparse offers with a randomly toggling r_ready shift the relative phase of the guards against the consumer. A long r_ready stall separates a design that waits correctly from one that drops the word or pulses r_valid anyway.

// File: rtl/ghs_pkg.sv
package ghs_pkg;

    typedef enum logic [1:0] {
        TX_IDLE     = 2'd0,
        TX_WAIT_ACK = 2'd1,
        TX_WAIT_REL = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_HOLD = 1'b1
    } rx_state_e;

    // receiver takes a word when the synchronized request is up and the consumer is ready
    function automatic logic rx_take(input logic req_seen, input logic consumer_ready);
        return req_seen & consumer_ready;
    endfunction

endpackage

// File: rtl/ghs_sync_cell.sv
// Dedicated single-stage synchronizer cell for one guard bit.
module ghs_sync_cell (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end
endmodule

// File: rtl/ghs_sender.sv
module ghs_sender
    import ghs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              busy,
    output logic              req,
    output logic [DATA_W-1:0] word_out,
    input  logic              ack_async
);
    tx_state_e         state;
    logic              ack_seen;
    logic [DATA_W-1:0] hold_q;

    ghs_sync_cell u_sync_ack_tx (
        .clk (clk),
        .rst (rst),
        .d   (ack_async),
        .q   (ack_seen)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            req    <= 1'b0;
            hold_q <= '0;
        end else begin
            unique case (state)
                TX_IDLE: if (in_valid) begin
                    hold_q <= in_data;
                    req    <= 1'b1;
                    state  <= TX_WAIT_ACK;
                end
                TX_WAIT_ACK: if (ack_seen) begin
                    req   <= 1'b0;
                    state <= TX_WAIT_REL;
                end
                TX_WAIT_REL: if (!ack_seen) state <= TX_IDLE;
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign busy     = (state != TX_IDLE);
    assign in_ready = (state == TX_IDLE);
    assign word_out = hold_q;

    a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(word_out));
    a_r9_req_fall_after_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(req) |-> $past(ack_seen));
    a_r9_req_rise_ack_low: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> !$past(ack_seen));
    a_r4_busy_ends_on_release: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !$past(ack_seen));
endmodule

// File: rtl/ghs_receiver.sv
module ghs_receiver
    import ghs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              sync_clk,
    input  logic              rst,
    input  logic              req_async,
    input  logic [DATA_W-1:0] word_in,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              ack
);
    rx_state_e state;
    logic      req_seen;

    ghs_sync_cell u_sync_req_rx (
        .clk (sync_clk),
        .rst (rst),
        .d   (req_async),
        .q   (req_seen)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_IDLE;
            ack       <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (state)
                RX_IDLE: if (rx_take(req_seen, out_ready)) begin
                    out_data  <= word_in;
                    out_valid <= 1'b1;
                    ack       <= 1'b1;
                    state     <= RX_HOLD;
                end
                RX_HOLD: if (!req_seen) begin
                    ack   <= 1'b0;
                    state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    a_r5_valid_needs_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(out_ready));
    a_r8_ack_after_req_seen: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(req_seen));
    a_r6_ack_with_delivery: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> out_valid);
endmodule

// File: rtl/ghs_cdc.sv
module ghs_cdc #(
    parameter int DATA_W = 16
) (
    input  logic              s_clk,
    input  logic              s_rst,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic              s_busy,
    input  logic              r_clk,
    input  logic              r_sync_clk,
    input  logic              r_rst,
    input  logic              r_ready,
    output logic              r_valid,
    output logic [DATA_W-1:0] r_data
);
    logic              req_guard;
    logic              ack_guard;
    logic [DATA_W-1:0] cross_word;

    ghs_sender #(.DATA_W(DATA_W)) u_tx (
        .clk       (s_clk),
        .rst       (s_rst),
        .in_valid  (s_valid),
        .in_data   (s_data),
        .in_ready  (s_ready),
        .busy      (s_busy),
        .req       (req_guard),
        .word_out  (cross_word),
        .ack_async (ack_guard)
    );

    ghs_receiver #(.DATA_W(DATA_W)) u_rx (
        .clk       (r_clk),
        .sync_clk  (r_sync_clk),
        .rst       (r_rst),
        .req_async (req_guard),
        .word_in   (cross_word),
        .out_ready (r_ready),
        .out_valid (r_valid),
        .out_data  (r_data),
        .ack       (ack_guard)
    );
endmodule

// File: tb/ghs_cdc_tb_top.sv
`timescale 1ns/1ps
module ghs_cdc_tb_top;
    localparam int W = 16;

    logic         s_clk = 1'b0, r_clk = 1'b0;
    logic         s_rst = 1'b1, r_rst = 1'b1;
    logic         s_valid = 1'b0;
    logic [W-1:0] s_data = '0;
    logic         s_ready, s_busy;
    logic         r_ready = 1'b1;
    logic         r_valid;
    logic [W-1:0] r_data;
    logic         r_sync_clk;

    int checks = 0, errors = 0;
    int accepted = 0, delivered = 0;
    int rmode = 0;             // 0 ready high, 1 random, 2 held low
    bit stall_valid_seen = 0;
    bit prev_valid = 0, prev_busy = 0;
    logic [W-1:0] expq[$];

    always #5    s_clk = ~s_clk;   // 100 MHz sender clock
    always #8.35 r_clk = ~r_clk;   // unrelated receiver clock
    assign r_sync_clk = r_clk;     // parallel sync clock

    ghs_cdc #(.DATA_W(W)) dut_i (
        .s_clk(s_clk), .s_rst(s_rst), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .s_busy(s_busy),
        .r_clk(r_clk), .r_sync_clk(r_sync_clk), .r_rst(r_rst),
        .r_ready(r_ready), .r_valid(r_valid), .r_data(r_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // receiver-side reference model and consumer driver
    always @(negedge r_clk) begin
        if (!r_rst) begin
            if (r_valid) begin
                check(!prev_valid, "R5 pulse width", 1, 0);
                check(r_ready, "R5 valid without ready", r_ready, 1);
                if (rmode == 2) stall_valid_seen = 1;
                if (expq.size() == 0) begin
                    check(0, "R7 extra word", r_data, 0);
                end else begin
                    logic [W-1:0] e;
                    e = expq.pop_front();
                    check(r_data == e, "R7 data order/value", r_data, e);
                end
                delivered++;
            end
            prev_valid = r_valid;
            case (rmode)
                0: r_ready = 1'b1;
                1: r_ready = (($urandom % 4) != 0);
                default: r_ready = 1'b0;
            endcase
        end
    end

    // busy must not end before the word was delivered
    always @(negedge s_clk) begin
        if (!s_rst) begin
            if (prev_busy && !s_busy)
                check(delivered == accepted, "R4 busy fell before delivery", delivered, accepted);
            prev_busy = s_busy;
        end
    end

    task automatic send_word(input logic [W-1:0] w);
        s_valid = 1'b1;
        s_data  = w;
        while (!s_ready) @(negedge s_clk);
        @(negedge s_clk);
        expq.push_back(w);
        accepted++;
        check(s_busy == 1'b1 && s_ready == 1'b0, "R2 busy after accept", {s_busy, s_ready}, 2);
        s_valid = 1'b0;
        s_data  = ~w;   // sender input changes; crossing word must not (R3)
    endtask

    task automatic drain();
        int guard = 0;
        while ((delivered != accepted || s_busy) && guard < 2000) begin
            @(negedge s_clk);
            guard++;
        end
    endtask

    initial begin
        bit timed_out = 0;
        fork
            begin
                repeat (4) @(negedge s_clk);
                check(s_ready == 1 && s_busy == 0 && r_valid == 0, "R1 reset state",
                      {s_ready, s_busy, r_valid}, 3'b100);
                @(negedge s_clk); s_rst = 1'b0;
                @(negedge r_clk); r_rst = 1'b0;
                repeat (3) @(negedge s_clk);
                // back-to-back incrementing words
                @(negedge s_clk);
                for (int i = 0; i < 16; i++) send_word(W'(16'h0100 + i));
                drain();
                // corner bit patterns
                send_word('0);
                send_word('1);
                send_word({(W/2){2'b10}});
                send_word({(W/2){2'b01}});
                drain();
                // sparse offers with random consumer readiness
                rmode = 1;
                for (int i = 0; i < 20; i++) begin
                    repeat ($urandom % 5) @(negedge s_clk);
                    send_word(W'($urandom));
                end
                drain();
                // long consumer stall with one pending word
                rmode = 2;
                repeat (4) @(negedge r_clk);
                send_word(W'(16'hBEEF));
                repeat (80) @(negedge s_clk);
                check(s_busy == 1'b1, "R6 busy held during stall", s_busy, 1);
                check(!stall_valid_seen, "R6 valid during stall", stall_valid_seen, 0);
                check(expq.size() == 1, "R6 word pending", expq.size(), 1);
                rmode = 0;
                drain();
                repeat (10) @(negedge s_clk);
                check(expq.size() == 0 && delivered == accepted, "R7 exactly once",
                      delivered, accepted);
                check(s_ready == 1 && s_busy == 0, "R4 idle after all transfers",
                      {s_ready, s_busy}, 2);
            end
            begin
                repeat (150000) @(posedge s_clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) check(0, "watchdog", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule